// File: doc/BRIEF.md
# Write-Once Line Coherence Controller

This block tracks the coherence state of each line of a snooping cache. It uses a write-once policy. The first write to a clean line is sent straight through to memory, and the line is marked as written once. Any later write stays in the cache, and the line becomes the sole up-to-date copy. The controller takes two kinds of input:

- requests from the local processor: read, write and replace;
- commands snooped from the shared bus: block read, read-invalidate and write-invalidate.

It keeps a 2-bit state for every line, indexed directly by line number. When a transition needs the bus, it raises a bus request and waits for the acknowledge before it commits the new state.

Requests are single-cycle pulses, and they are taken only while `busy` is low. A pulse of `op_done` marks the cycle after the state update. The data array, the arbiter and memory sit outside the block. The cache pipeline can read any line's state through a registered lookup port.

Top module: `wonce_coh_ctrl`

## Requirements
- R1: After reset every line reads state Invalid (encoding: Invalid 0, Valid 1, Reserved 2, Dirty 3). `busy`, `bus_req` and `op_done` are low.
- R2: A local read (op 0) of an Invalid line issues a fetch (bus command 0) and ends in Valid. A read of a Valid line ends in Valid without bus traffic. A read of a Reserved or Dirty line keeps its state without bus traffic.
- R3: A local write (op 1) to a Valid line issues a write-through (bus command 2) and ends in Reserved.
- R4: A local write to a Reserved or Dirty line ends in Dirty with no bus request. `op_done` is high in the cycle after the request.
- R5: A local write to an Invalid line issues a read-invalidate (bus command 1) and ends in Dirty.
- R6: Snoop commands are encoded as 1 block read, 2 read-invalidate and 3 write-invalidate.
  - A snooped block read of a Valid or Reserved line gives Valid.
  - A snooped read-invalidate of a Valid or Reserved line gives Invalid.
  - A snooped write-invalidate of any line gives Invalid.
  - None of these uses the bus, and snoops on an Invalid line change nothing.
- R7: A Dirty line hit by a snooped block read or read-invalidate issues a write-back (bus command 3). It becomes Valid or Invalid respectively, but only after the acknowledge.
- R8: A local replace (op 2) of a Dirty line issues a write-back and ends in Invalid after the acknowledge.
- R9: A local replace of an Invalid, Valid or Reserved line ends in Invalid with no bus request.
- R10: If a snoop and a local request arrive in the same cycle, only the snoop is processed. The local request is dropped.
- R11: While `busy` is high, request pulses are ignored. A `bus_ack` that arrives with no bus request pending has no effect.
- R12: `bus_req`, `bus_cmd` and `bus_idx` hold steady until `bus_ack`. On the acknowledge edge the request drops, `busy` falls, the state is written and `op_done` pulses once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_valid | input | 1 | Local request pulse |
| lreq_op | input | 2 | Local operation: 0 read, 1 write, 2 replace, 3 no-op |
| lreq_idx | input | IDX_W | Line addressed by the local request |
| snp_valid | input | 1 | Snoop command pulse |
| snp_cmd | input | 2 | Snoop: 0 none, 1 block read, 2 read-invalidate, 3 write-invalidate |
| snp_idx | input | IDX_W | Line addressed by the snoop |
| bus_req | output | 1 | Bus action request, held until acknowledged |
| bus_cmd | output | 2 | Bus action: 0 fetch, 1 read-invalidate, 2 write-through, 3 write-back |
| bus_idx | output | IDX_W | Line of the bus action |
| bus_ack | input | 1 | Bus action complete |
| busy | output | 1 | A bus action is outstanding |
| op_done | output | 1 | One-cycle completion pulse |
| look_idx | input | IDX_W | Lookup line |
| look_state | output | 2 | Registered state of `look_idx` |

## Verification
A request needing no bus time is taken at clock edge k. At that same edge the state is written and `op_done` rises, so the bench samples on the falling edge after k. A request needing the bus raises `bus_req` at edge k. `op_done` then rises at the edge where `bus_ack` is seen high, and the bench holds the acknowledge off for a chosen number of cycles while checking that nothing completes early. A line's state shows on `look_state` one edge after `look_idx` is set, so every state check drives the index, waits one edge and reads on the next falling edge.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_VAL = 2'd1,
    ST_RSV = 2'd2,
    ST_DRT = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    LOP_RD  = 2'd0,
    LOP_WR  = 2'd1,
    LOP_RPL = 2'd2,
    LOP_NOP = 2'd3
  } lop_t;

  typedef enum logic [1:0] {
    SNP_NONE = 2'd0,
    SNP_BRD  = 2'd1,
    SNP_RDI  = 2'd2,
    SNP_WRI  = 2'd3
  } snp_t;

  typedef enum logic [1:0] {
    BC_FETCH = 2'd0,
    BC_RDINV = 2'd1,
    BC_WTHRU = 2'd2,
    BC_WBACK = 2'd3
  } bcmd_t;
endpackage

// File: rtl/coh_next.sv
module coh_next
  import coh_pkg::*;
(
  input  logic       is_snp,
  input  logic [1:0] lop,
  input  logic [1:0] scmd,
  input  logic [1:0] cur,
  output logic       need_bus,
  output logic [1:0] cmd,
  output logic [1:0] nxt
);
  line_st_t cs;
  assign cs = line_st_t'(cur);

  always_comb begin
    need_bus = 1'b0;
    cmd      = BC_FETCH;
    nxt      = cur;
    if (is_snp) begin
      unique case (snp_t'(scmd))
        SNP_BRD: begin
          if (cs == ST_DRT) begin
            need_bus = 1'b1;
            cmd      = BC_WBACK;
            nxt      = ST_VAL;
          end else if (cs != ST_INV) begin
            nxt = ST_VAL;
          end
        end
        SNP_RDI: begin
          if (cs == ST_DRT) begin
            need_bus = 1'b1;
            cmd      = BC_WBACK;
          end
          nxt = ST_INV;
        end
        SNP_WRI: nxt = ST_INV;
        default: nxt = cur;
      endcase
    end else begin
      unique case (lop_t'(lop))
        LOP_RD: begin
          if (cs == ST_INV) begin
            need_bus = 1'b1;
            cmd      = BC_FETCH;
            nxt      = ST_VAL;
          end
        end
        LOP_WR: begin
          unique case (cs)
            ST_INV: begin
              need_bus = 1'b1;
              cmd      = BC_RDINV;
              nxt      = ST_DRT;
            end
            ST_VAL: begin
              need_bus = 1'b1;
              cmd      = BC_WTHRU;
              nxt      = ST_RSV;
            end
            default: nxt = ST_DRT;
          endcase
        end
        LOP_RPL: begin
          if (cs == ST_DRT) begin
            need_bus = 1'b1;
            cmd      = BC_WBACK;
          end
          nxt = ST_INV;
        end
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/coh_state_ram.sv
module coh_state_ram #(
  parameter int LINES = 16,
  parameter int IDX_W = 4,
  parameter int ST_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [ST_W-1:0]  wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [ST_W-1:0]  rdata,
  input  logic [IDX_W-1:0] lidx,
  output logic [ST_W-1:0]  ldata
);
  logic [ST_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ldata <= '0;
    else     ldata <= mem[lidx];
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/wonce_coh_ctrl.sv
module wonce_coh_ctrl
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lreq_valid,
  input  logic [1:0]       lreq_op,
  input  logic [IDX_W-1:0] lreq_idx,
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             bus_req,
  output logic [1:0]       bus_cmd,
  output logic [IDX_W-1:0] bus_idx,
  input  logic             bus_ack,
  output logic             busy,
  output logic             op_done,
  input  logic [IDX_W-1:0] look_idx,
  output logic [1:0]       look_state
);
  logic             take;
  logic             sel_snp;
  logic [IDX_W-1:0] sel_idx;
  logic [1:0]       cur_st;
  logic             need_bus;
  logic [1:0]       dec_cmd;
  logic [1:0]       dec_nxt;
  logic [1:0]       pend_nxt;
  logic             we;
  logic [IDX_W-1:0] widx;
  logic [1:0]       wdata;

  // Snoops take precedence; nothing is taken while a bus action is open.
  assign sel_snp = snp_valid;
  assign take    = !busy && (snp_valid || lreq_valid);
  assign sel_idx = sel_snp ? snp_idx : lreq_idx;

  coh_state_ram #(.LINES(LINES), .IDX_W(IDX_W), .ST_W(2)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .widx  (widx),
    .wdata (wdata),
    .ridx  (sel_idx),
    .rdata (cur_st),
    .lidx  (look_idx),
    .ldata (look_state)
  );

  coh_next u_next (
    .is_snp   (sel_snp),
    .lop      (lreq_op),
    .scmd     (snp_cmd),
    .cur      (cur_st),
    .need_bus (need_bus),
    .cmd      (dec_cmd),
    .nxt      (dec_nxt)
  );

  always_comb begin
    we    = 1'b0;
    widx  = sel_idx;
    wdata = dec_nxt;
    if (busy) begin
      we    = bus_ack;
      widx  = bus_idx;
      wdata = pend_nxt;
    end else if (take && !need_bus) begin
      we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      bus_req  <= 1'b0;
      bus_cmd  <= BC_FETCH;
      bus_idx  <= '0;
      op_done  <= 1'b0;
      pend_nxt <= ST_INV;
    end else begin
      op_done <= 1'b0;
      if (busy) begin
        if (bus_ack) begin
          busy    <= 1'b0;
          bus_req <= 1'b0;
          op_done <= 1'b1;
        end
      end else if (take) begin
        if (need_bus) begin
          busy     <= 1'b1;
          bus_req  <= 1'b1;
          bus_cmd  <= dec_cmd;
          bus_idx  <= sel_idx;
          pend_nxt <= dec_nxt;
        end else begin
          op_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/coh_chk.sv
module coh_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             lreq_valid,
  input logic [1:0]       lreq_op,
  input logic             snp_valid,
  input logic             bus_req,
  input logic [1:0]       bus_cmd,
  input logic [IDX_W-1:0] bus_idx,
  input logic             bus_ack,
  input logic             busy,
  input logic             op_done
);
  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_cmd) && $stable(bus_idx));

  // R12
  ack_finish_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req && !busy && op_done);

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && bus_ack && !lreq_valid && !snp_valid |=> !op_done && !bus_req);

  // R11
  busy_pending_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !bus_ack |=> !op_done);

  // R2
  read_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && lreq_valid && !snp_valid && lreq_op == 2'd0 |=> !bus_req || bus_cmd == 2'd0);

  // R8
  replace_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && lreq_valid && !snp_valid && lreq_op == 2'd2 |=> !bus_req || bus_cmd == 2'd3);
endmodule

bind wonce_coh_ctrl coh_chk #(.IDX_W(IDX_W)) u_coh_chk (
  .clk        (clk),
  .rst        (rst),
  .lreq_valid (lreq_valid),
  .lreq_op    (lreq_op),
  .snp_valid  (snp_valid),
  .bus_req    (bus_req),
  .bus_cmd    (bus_cmd),
  .bus_idx    (bus_idx),
  .bus_ack    (bus_ack),
  .busy       (busy),
  .op_done    (op_done)
);

// File: tb/wonce_coh_ctrl_test.sv
module wonce_coh_ctrl_test;
  localparam int LINES = 16;
  localparam int IW    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lreq_valid = 1'b0;
  logic [1:0]    lreq_op = 2'd0;
  logic [IW-1:0] lreq_idx = '0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = 2'd0;
  logic [IW-1:0] snp_idx = '0;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [IW-1:0] bus_idx;
  logic          bus_ack = 1'b0;
  logic          busy;
  logic          op_done;
  logic [IW-1:0] look_idx = '0;
  logic [1:0]    look_state;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  wonce_coh_ctrl #(.LINES(LINES)) uut (
    .clk(clk), .rst(rst),
    .lreq_valid(lreq_valid), .lreq_op(lreq_op), .lreq_idx(lreq_idx),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_idx(bus_idx), .bus_ack(bus_ack),
    .busy(busy), .op_done(op_done),
    .look_idx(look_idx), .look_state(look_state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic peek(input int idx, input int exp, input string tag);
    @(negedge clk);
    look_idx = idx[IW-1:0];
    @(posedge clk);
    @(negedge clk);
    chk(look_state == exp[1:0], tag, look_state, exp);
  endtask

  // Shared completion: either an immediate done, or a bus action acked after dly cycles.
  task automatic finish_op(input bit exp_bus, input int exp_cmd, input int idx,
                           input int dly, input string tag);
    if (exp_bus) begin
      chk(bus_req == 1'b1, {tag, " bus_req"}, bus_req, 1);
      chk(bus_cmd == exp_cmd[1:0], {tag, " bus_cmd"}, bus_cmd, exp_cmd);
      chk(bus_idx == idx[IW-1:0], {tag, " bus_idx"}, bus_idx, idx);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk(bus_req && !op_done, {tag, " held"}, op_done, 0);
      end
      bus_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_ack = 1'b0;
      chk(op_done && !bus_req && !busy, {tag, " ack done"}, op_done, 1);
    end else begin
      chk(op_done && !bus_req, {tag, " no-bus done"}, {op_done, bus_req}, 2);
    end
  endtask

  task automatic local_op(input int op, input int idx, input bit exp_bus,
                          input int exp_cmd, input int dly, input string tag);
    @(negedge clk);
    lreq_valid = 1'b1; lreq_op = op[1:0]; lreq_idx = idx[IW-1:0];
    @(posedge clk);
    @(negedge clk);
    lreq_valid = 1'b0;
    finish_op(exp_bus, exp_cmd, idx, dly, tag);
  endtask

  task automatic snoop_op(input int cmd, input int idx, input bit exp_bus,
                          input int dly, input string tag);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd[1:0]; snp_idx = idx[IW-1:0];
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    finish_op(exp_bus, 3, idx, dly, tag);
  endtask

  task automatic t_reset;
    chk(!busy && !bus_req && !op_done, "R1 outputs", {busy, bus_req, op_done}, 0);
    peek(0, 0, "R1 line0");
    peek(15, 0, "R1 line15");
  endtask

  task automatic t_read_write;
    local_op(0, 3, 1, 0, 2, "R2 read miss");
    peek(3, 1, "R2 valid");
    local_op(0, 3, 0, 0, 0, "R2 read hit");
    peek(3, 1, "R2 still valid");
    local_op(1, 3, 1, 2, 1, "R3 first write");
    peek(3, 2, "R3 reserved");
    snoop_op(1, 3, 0, 0, "R6 snoop read reserved");
    peek(3, 1, "R6 back to valid");
    local_op(1, 3, 1, 2, 0, "R3 write again");
    local_op(1, 3, 0, 0, 0, "R4 second write");
    peek(3, 3, "R4 dirty");
    local_op(1, 3, 0, 0, 0, "R4 write dirty");
    local_op(0, 3, 0, 0, 0, "R2 read dirty");
    peek(3, 3, "R2 dirty kept");
    local_op(2, 3, 1, 3, 3, "R8 replace dirty");
    peek(3, 0, "R8 invalid");
  endtask

  task automatic t_write_miss;
    local_op(1, 5, 1, 1, 1, "R5 write miss");
    peek(5, 3, "R5 dirty");
    snoop_op(1, 5, 1, 2, "R7 snoop read dirty");
    peek(5, 1, "R7 valid");
    local_op(1, 8, 1, 1, 0, "R5 write miss 8");
    snoop_op(2, 8, 1, 1, "R7 snoop rdinv dirty");
    peek(8, 0, "R7 invalid");
  endtask

  task automatic t_snoop_inval;
    local_op(0, 7, 1, 0, 0, "R2 read miss 7");
    snoop_op(3, 7, 0, 0, "R6 write-inval");
    peek(7, 0, "R6 invalid");
    local_op(0, 6, 1, 0, 0, "R2 read miss 6");
    snoop_op(2, 6, 0, 0, "R6 rdinv valid");
    peek(6, 0, "R6 invalid 6");
    snoop_op(1, 6, 0, 0, "R6 snoop on invalid");
    peek(6, 0, "R6 invalid unchanged");
  endtask

  task automatic t_replace_clean;
    local_op(0, 9, 1, 0, 0, "R2 read miss 9");
    local_op(1, 9, 1, 2, 0, "R3 write 9");
    local_op(2, 9, 0, 0, 0, "R9 replace reserved");
    peek(9, 0, "R9 invalid");
  endtask

  task automatic t_priority;
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_idx = 4'd9;
    lreq_valid = 1'b1; lreq_op = 2'd0; lreq_idx = 4'd10;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0; lreq_valid = 1'b0;
    chk(op_done && !bus_req, "R10 snoop done, no fetch", bus_req, 0);
    @(negedge clk);
    chk(!op_done && !bus_req, "R10 local dropped", op_done, 0);
    peek(10, 0, "R10 line10 invalid");
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    lreq_valid = 1'b1; lreq_op = 2'd0; lreq_idx = 4'd11;
    @(posedge clk);
    @(negedge clk);
    lreq_valid = 1'b1; lreq_op = 2'd1; lreq_idx = 4'd12;
    snp_valid = 1'b1; snp_cmd = 2'd3; snp_idx = 4'd11;
    @(posedge clk);
    @(negedge clk);
    lreq_valid = 1'b0; snp_valid = 1'b0;
    finish_op(1, 0, 11, 1, "R11 busy");
    @(negedge clk);
    chk(!op_done && !bus_req, "R11 no extra op", op_done, 0);
    peek(12, 0, "R11 line12 untouched");
    peek(11, 1, "R11 line11 valid");
    @(negedge clk);
    bus_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_ack = 1'b0;
    chk(!op_done && !busy && !bus_req, "R11 stray ack", op_done, 0);
    peek(11, 1, "R11 stray ack state");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_read_write();
    t_write_miss();
    t_snoop_inval();
    t_replace_clean();
    t_priority();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule